// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block is the front end of a 64-bit sequential processor core. Each cycle it receives a ten-byte window of instruction memory, which begins at the current program counter. It also receives a fetch-error flag and a data-memory error flag. From these it works out which instruction is present and how long it is (1, 2, 9 or 10 bytes). It pulls out the register specifiers and the 64-bit constant, and computes the address of the next sequential instruction.

The block is purely combinational. It sits between the instruction memory read port and the decode logic. When the fetch itself faults, a nop is substituted so that the rest of the core sees a harmless instruction. A two-bit status code merges the fetch error, the data-memory error, the instruction-validity test and halt detection under a fixed priority.

Top module: `fetch_aligner`

## Requirements
- R1: Window byte k occupies bits 8k+7..8k of `win_i`. Opcode `op_o` is bits 7..4 of byte 0, and function `fn_o` is bits 3..0 of byte 0.
- R2: When `imem_err_i` is 1, `op_o` is forced to the nop code 1 and `fn_o` to 0, whatever byte 0 holds.
- R3: `valid_o` is 1 exactly when the effective opcode is 0x0 through 0xB.
- R4: A register byte is present (`has_regs_o`=1) for opcodes 2, 3, 4, 5, 6, 0xA and 0xB. The register byte is byte 1. When it is present, `ra_o` is its high nibble and `rb_o` its low nibble. Otherwise both are 0xF.
- R5: An 8-byte constant is present (`has_const_o`=1) for opcodes 3, 4, 5, 7 and 8. For opcodes 7 and 8 it starts at byte 1; for opcodes 3, 4 and 5 it starts at byte 2. The lowest-addressed byte is the least significant. When no constant is present, `const_o` is 0.
- R6: The instruction length is 1 + (register byte present) + 8·(constant present). This gives 1 byte for 0, 1, 9 and invalid opcodes; 2 bytes for 2, 6, 0xA and 0xB; 9 bytes for 7 and 8; and 10 bytes for 3, 4 and 5. `next_pc_o` = `pc_i` + length, modulo 2^64.
- R7: `stat_o` encodes OK=0, HALT=1, ADDR=2, ILLEGAL=3. Either error flag gives ADDR. Otherwise an invalid opcode gives ILLEGAL. Otherwise opcode 0 gives HALT. Otherwise the result is OK.
- R8: A data-memory error alone (`dmem_err_i`=1, `imem_err_i`=0) does not alter opcode, operands, constant or next PC. It only sets `stat_o` to ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of byte 0 of the window |
| win_i | input | 80 | Ten fetched bytes, byte k in bits 8k+7..8k |
| imem_err_i | input | 1 | Instruction fetch faulted |
| dmem_err_i | input | 1 | Data memory access faulted |
| op_o | output | 4 | Effective opcode |
| fn_o | output | 4 | Effective function code |
| ra_o | output | 4 | First register specifier or 0xF |
| rb_o | output | 4 | Second register specifier or 0xF |
| const_o | output | 64 | Extracted constant or 0 |
| next_pc_o | output | 64 | Fall-through address |
| has_regs_o | output | 1 | Register byte present |
| has_const_o | output | 1 | Constant present |
| valid_o | output | 1 | Opcode is defined |
| stat_o | output | 2 | Combined status code |

## Verification
The embedded assertions check several properties at every evaluation. A fetch fault always yields a nop with function 0. The length implied by `next_pc_o` is always one of the four legal values. Absent register bytes read as 0xF. Any error flag forces ADDR. An invalid opcode never reports OK or HALT. Only the bench's sweep can show the exact byte placement of the constant for each opcode class. The same holds for the opcode-to-length mapping for each opcode, pointer wrap at the top of the address space, and the fact that a data-memory error leaves the decoded fields untouched.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam logic [3:0] OPC_HALT   = 4'h0;
  localparam logic [3:0] OPC_NOP    = 4'h1;
  localparam logic [3:0] OPC_CMOV   = 4'h2;
  localparam logic [3:0] OPC_IRMOV  = 4'h3;
  localparam logic [3:0] OPC_RMMOV  = 4'h4;
  localparam logic [3:0] OPC_MRMOV  = 4'h5;
  localparam logic [3:0] OPC_ALU    = 4'h6;
  localparam logic [3:0] OPC_JUMP   = 4'h7;
  localparam logic [3:0] OPC_CALL   = 4'h8;
  localparam logic [3:0] OPC_RET    = 4'h9;
  localparam logic [3:0] OPC_PUSH   = 4'hA;
  localparam logic [3:0] OPC_POP    = 4'hB;
  localparam logic [3:0] FN_NONE    = 4'h0;
  localparam logic [3:0] REG_NONE   = 4'hF;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_HALT    = 2'd1,
    ST_ADDR    = 2'd2,
    ST_ILLEGAL = 2'd3
  } stat_e;
endpackage

// File: rtl/fetch_split.sv
module fetch_split
  import fetch_pkg::*;
(
  input  logic [7:0] byte0_i,
  input  logic       err_i,
  output logic [3:0] op_o,
  output logic [3:0] fn_o
);
  always_comb begin
    if (err_i) begin
      op_o = OPC_NOP;
      fn_o = FN_NONE;
    end else begin
      op_o = byte0_i[7:4];
      fn_o = byte0_i[3:0];
    end
  end

  always_comb begin
    a_r2_fault_gives_nop: assert (!err_i || (op_o == OPC_NOP && fn_o == FN_NONE))
      else $error("R2: fetch fault did not yield nop");
  end
endmodule

// File: rtl/fetch_classify.sv
module fetch_classify
  import fetch_pkg::*;
#(
  parameter int CONST_BYTES = 8,
  parameter int LEN_W       = $clog2(CONST_BYTES + 3)
)(
  input  logic [3:0]       op_i,
  output logic             valid_o,
  output logic             regs_o,
  output logic             const_o,
  output logic             const_early_o,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] CONST_LEN = LEN_W'(CONST_BYTES);

  always_comb begin
    valid_o       = (op_i <= OPC_POP);
    regs_o        = 1'b0;
    const_o       = 1'b0;
    const_early_o = 1'b0;
    case (op_i)
      OPC_CMOV, OPC_ALU, OPC_PUSH, OPC_POP: regs_o = 1'b1;
      OPC_IRMOV, OPC_RMMOV, OPC_MRMOV: begin
        regs_o  = 1'b1;
        const_o = 1'b1;
      end
      OPC_JUMP, OPC_CALL: begin
        const_o       = 1'b1;
        const_early_o = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    len_o = LEN_W'(1);
    if (regs_o)  len_o = len_o + LEN_W'(1);
    if (const_o) len_o = len_o + CONST_LEN;
  end

  always_comb begin
    a_r5_early_needs_const: assert (!const_early_o || (const_o && !regs_o))
      else $error("R5: early constant without constant flag");
  end
endmodule

// File: rtl/fetch_extract.sv
module fetch_extract
  import fetch_pkg::*;
#(
  parameter int CONST_BYTES = 8,
  localparam int TAIL_W = (CONST_BYTES + 1) * 8,
  localparam int CONST_W = CONST_BYTES * 8
)(
  input  logic [TAIL_W-1:0]  tail_i,
  input  logic               regs_i,
  input  logic               const_i,
  input  logic               early_i,
  output logic [3:0]         ra_o,
  output logic [3:0]         rb_o,
  output logic [CONST_W-1:0] const_o
);
  logic [CONST_W-1:0] from_b1;
  logic [CONST_W-1:0] from_b2;
  logic [7:0]         last_byte;

  assign last_byte = tail_i[TAIL_W-1 -: 8];

  for (genvar j = 0; j < CONST_BYTES; j++) begin : g_bytes
    assign from_b1[8*j +: 8] = tail_i[8*j +: 8];
    if (j < CONST_BYTES - 1) begin : g_mid
      assign from_b2[8*j +: 8] = tail_i[8*(j+1) +: 8];
    end else begin : g_top
      assign from_b2[8*j +: 8] = last_byte;
    end
  end

  always_comb begin
    if (regs_i) begin
      ra_o = tail_i[7:4];
      rb_o = tail_i[3:0];
    end else begin
      ra_o = REG_NONE;
      rb_o = REG_NONE;
    end
    if (!const_i)     const_o = '0;
    else if (early_i) const_o = from_b1;
    else              const_o = from_b2;
  end

  always_comb begin
    a_r4_absent_regs_none: assert (regs_i || (ra_o == REG_NONE && rb_o == REG_NONE))
      else $error("R4: absent register byte not 0xF");
    a_r5_absent_const_zero: assert (const_i || const_o == '0)
      else $error("R5: absent constant not zero");
  end
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner
  import fetch_pkg::*;
#(
  parameter int CONST_BYTES = 8,
  parameter int ADDR_W      = 64,
  localparam int WIN_W   = (CONST_BYTES + 2) * 8,
  localparam int CONST_W = CONST_BYTES * 8
)(
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [WIN_W-1:0]   win_i,
  input  logic               imem_err_i,
  input  logic               dmem_err_i,
  output logic [3:0]         op_o,
  output logic [3:0]         fn_o,
  output logic [3:0]         ra_o,
  output logic [3:0]         rb_o,
  output logic [CONST_W-1:0] const_o,
  output logic [ADDR_W-1:0]  next_pc_o,
  output logic               has_regs_o,
  output logic               has_const_o,
  output logic               valid_o,
  output logic [1:0]         stat_o
);
  localparam int LEN_W = $clog2(CONST_BYTES + 3);

  logic             early;
  logic [LEN_W-1:0] len;
  stat_e            stat;

  fetch_split u_split (
    .byte0_i (win_i[7:0]),
    .err_i   (imem_err_i),
    .op_o    (op_o),
    .fn_o    (fn_o)
  );

  fetch_classify #(.CONST_BYTES(CONST_BYTES), .LEN_W(LEN_W)) u_class (
    .op_i          (op_o),
    .valid_o       (valid_o),
    .regs_o        (has_regs_o),
    .const_o       (has_const_o),
    .const_early_o (early),
    .len_o         (len)
  );

  fetch_extract #(.CONST_BYTES(CONST_BYTES)) u_extract (
    .tail_i  (win_i[WIN_W-1:8]),
    .regs_i  (has_regs_o),
    .const_i (has_const_o),
    .early_i (early),
    .ra_o    (ra_o),
    .rb_o    (rb_o),
    .const_o (const_o)
  );

  assign next_pc_o = pc_i + ADDR_W'(len);

  always_comb begin
    if (imem_err_i || dmem_err_i) stat = ST_ADDR;
    else if (!valid_o)            stat = ST_ILLEGAL;
    else if (op_o == OPC_HALT)    stat = ST_HALT;
    else                          stat = ST_OK;
  end
  assign stat_o = stat;

  logic [ADDR_W-1:0] step;
  assign step = next_pc_o - pc_i;

  always_comb begin
    a_r6_legal_length: assert (step == ADDR_W'(1) || step == ADDR_W'(2) ||
                               step == ADDR_W'(CONST_BYTES + 1) ||
                               step == ADDR_W'(CONST_BYTES + 2))
      else $error("R6: illegal instruction length");
    a_r7_error_is_addr: assert (!(imem_err_i || dmem_err_i) || stat_o == ST_ADDR)
      else $error("R7: error flag not reported as ADDR");
    a_r3_invalid_not_ok: assert (valid_o || stat_o == ST_ADDR || stat_o == ST_ILLEGAL)
      else $error("R3: invalid opcode reported as runnable");
  end
endmodule

// File: tb/fetch_aligner_test.sv
module fetch_aligner_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pc_i;
  logic [79:0] win_i;
  logic        imem_err_i, dmem_err_i;
  logic [3:0]  op_o, fn_o, ra_o, rb_o;
  logic [63:0] const_o, next_pc_o;
  logic        has_regs_o, has_const_o, valid_o;
  logic [1:0]  stat_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fetch_aligner uut (
    .pc_i(pc_i), .win_i(win_i), .imem_err_i(imem_err_i), .dmem_err_i(dmem_err_i),
    .op_o(op_o), .fn_o(fn_o), .ra_o(ra_o), .rb_o(rb_o), .const_o(const_o),
    .next_pc_o(next_pc_o), .has_regs_o(has_regs_o), .has_const_o(has_const_o),
    .valid_o(valid_o), .stat_o(stat_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pc_i = '0; win_i = '0; imem_err_i = 1'b0; dmem_err_i = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // all-zero window is a halt: R7 status HALT, R6 length 1
    check(stat_o == 2'd1, "R7", 64'(stat_o), 64'd1);
    check(next_pc_o == 64'd1, "R6", next_pc_o, 64'd1);
    for (int idx = 0; idx < 1024; idx++) begin
      logic [7:0]  b0;
      logic        ie, de;
      logic [3:0]  eop, efn, era, erb;
      logic        eregs, econst, evalid;
      logic [63:0] ec, epc, enext;
      logic [1:0]  est;
      int          off;
      b0 = idx[7:0];
      ie = idx[8];
      de = idx[9];
      for (int k = 0; k < 10; k++)
        win_i[8*k +: 8] = (k == 0) ? b0 : 8'((idx * 37 + k * 53 + 11) % 256);
      if (idx % 4 == 0) epc = 64'hFFFF_FFFF_FFFF_FFFF - 64'(idx % 16);
      else              epc = 64'h1000 * 64'(idx) + 64'(idx);
      pc_i = epc;
      imem_err_i = ie;
      dmem_err_i = de;
      @(posedge clk);
      @(negedge clk);
      eop = ie ? 4'h1 : b0[7:4];
      efn = ie ? 4'h0 : b0[3:0];
      evalid = (eop <= 4'hB);
      eregs  = (eop == 4'h2 || eop == 4'h3 || eop == 4'h4 || eop == 4'h5 ||
                eop == 4'h6 || eop == 4'hA || eop == 4'hB);
      econst = (eop == 4'h3 || eop == 4'h4 || eop == 4'h5 || eop == 4'h7 || eop == 4'h8);
      era = eregs ? win_i[15:12] : 4'hF;
      erb = eregs ? win_i[11:8]  : 4'hF;
      off = (eop == 4'h7 || eop == 4'h8) ? 1 : 2;
      ec = '0;
      if (econst)
        for (int j = 0; j < 8; j++) ec[8*j +: 8] = win_i[8*(off+j) +: 8];
      enext = epc + 64'(1 + int'(eregs) + 8 * int'(econst));
      if (ie || de)       est = 2'd2;
      else if (!evalid)   est = 2'd3;
      else if (eop == 0)  est = 2'd1;
      else                est = 2'd0;
      // R1 nibble split; R2 fault substitution; R8 data error leaves decode alone
      check(op_o == eop && fn_o == efn, ie ? "R2" : (de ? "R8" : "R1"),
            64'({op_o, fn_o}), 64'({eop, efn}));
      check(valid_o == evalid, "R3", 64'(valid_o), 64'(evalid));
      check(has_regs_o == eregs && ra_o == era && rb_o == erb, "R4",
            64'({has_regs_o, ra_o, rb_o}), 64'({eregs, era, erb}));
      check(has_const_o == econst && const_o == ec, "R5", const_o, ec);
      check(next_pc_o == enext, "R6", next_pc_o, enext);
      check(stat_o == est, "R7", 64'(stat_o), 64'(est));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule